// File: doc/BRIEF.md
# Reloading Interval Timer

This block is a periodic down-counting timer for a processor subsystem. Software programs a reload value (the divisor), then issues control writes: one operation copies the divisor into the counter and leaves it stopped, and a separate operation starts it. A running counter steps down by one on each count tick. The count tick comes from a selectable prescaler on the block clock. When the counter is due to wrap, it reloads from the divisor and keeps running, so it produces a steady periodic tick. For example, a divisor of 1,000,000 at a 100 MHz count rate gives 100 ticks per second.

Each wrap sets a pending status bit. Software reads the status only through a mask, and clears it by writing a one to an acknowledge address. The interrupt output follows the masked status and stays high until the status is acknowledged. The live counter can be read at any time, so software can interpolate time between ticks.

The register port is a plain single-cycle write strobe with a combinational read mux. It has no back-pressure: every write is taken in the cycle its strobe is high.

Top module: `ivtimer`

## Requirements
- R1: After reset the counter, divisor, mask and pending status are zero, the timer is stopped and `irq` is low.
- R2: A write to address 1 with bits [1:0] equal to 1 (load) copies the divisor into the counter, and the counter then stays at that value.
- R3: After a write to address 1 with bits [1:0] equal to 2 (run), the counter falls by one on every count tick, starting with the first tick after the write. A control write with bits [1:0] equal to 0 or 3 (hold) freezes the counter.
- R4: Control bits [3:2] select the count rate. Code n gives one tick every 2^(PRE_STEP*n) clocks, which is 1, 4, 16 or 64 clocks by default. Code 0 ticks on every clock. Every control write restarts the prescaler.
- R5: On a tick while the counter is 1 or 0, the counter reloads the divisor instead of decrementing, and it keeps running. The period is therefore the divisor in ticks, and a read just after the wrap returns a larger value than the read just before it.
- R6: A divisor write while the timer is running leaves the counter untouched. The new value is used at the next reload.
- R7: Every reload caused by a wrap sets the pending status bit.
- R8: A read of address 4 returns the pending status ANDed with mask bit 0 (address 3) in bit 0. `irq` equals that masked value and stays high until the status is acknowledged.
- R9: A write to address 5 with bit 0 set clears the pending status. The same write with bit 0 clear has no effect.
- R10: If a wrap and an acknowledge fall in the same cycle, the pending status remains set.
- R11: Reads return the divisor at address 0, the control fields at address 1 (operation in [1:0], rate in [3:2]), the counter at address 2, and the mask at address 3. All other addresses read zero. Writes to addresses 2 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken on the rising edge |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | 1 | Tick interrupt, OR of masked pending bits |

## Verification
The race that matters is a wrap of the counter arriving in the same clock edge as an acknowledge write. The bench counts clocks from a run write with a small divisor and places the acknowledge strobe exactly on the reloading edge. It then requires both the reloaded counter and a still-pending masked status with `irq` high. A second collision, a divisor write landing mid-period, is judged by requiring that the counter keep its old sequence and adopt the new value only at the following reload.

// File: rtl/ivtimer_pkg.sv
`timescale 1ns/1ps
package ivtimer_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_RUN   = 2'd2,
    OP_HOLD3 = 2'd3
  } op_e;

  localparam int AW = 3;

  localparam logic [AW-1:0] A_DIV   = 3'd0;
  localparam logic [AW-1:0] A_CTRL  = 3'd1;
  localparam logic [AW-1:0] A_COUNT = 3'd2;
  localparam logic [AW-1:0] A_MASK  = 3'd3;
  localparam logic [AW-1:0] A_MSTAT = 3'd4;
  localparam logic [AW-1:0] A_ACK   = 3'd5;

  localparam int OP_LSB   = 0;
  localparam int RATE_LSB = 2;

endpackage

// File: rtl/ivt_prescaler.sv
`timescale 1ns/1ps
module ivt_prescaler #(
  parameter int SEL_W    = 2,
  parameter int PRE_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int NSEL = 1 << SEL_W;
  localparam int PW   = (PRE_STEP * (NSEL - 1) > 0) ? PRE_STEP * (NSEL - 1) : 1;
  localparam logic [PW:0] ONE = 1;

  logic [PW:0]   lim_tab [NSEL];
  logic [PW-1:0] pcnt_q;

  // one clock-division limit per rate code
  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim_tab[g] = ONE << (PRE_STEP * g);
  end

  assign tick = run && ({1'b0, pcnt_q} == (lim_tab[sel] - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (restart || !run || tick) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ivt_counter.sv
`timescale 1ns/1ps
module ivt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] cnt_q;

  // a load has priority; a tick at 1 or 0 reloads instead of decrementing
  assign wrap  = tick && !load && (cnt_q <= ONE);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || wrap) begin
      cnt_q <= reload_val;
    end else if (tick) begin
      cnt_q <= cnt_q - ONE;
    end
  end

endmodule

// File: rtl/ivt_irq.sv
`timescale 1ns/1ps
module ivt_irq #(
  parameter int NSRC = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] ack,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_d,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] masked,
  output logic            irq
);

  logic [NSRC-1:0] st_q;
  logic [NSRC-1:0] mk_q;

  assign status = st_q;
  assign mask   = mk_q;
  assign masked = st_q & mk_q;
  assign irq    = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      mk_q <= '0;
    end else begin
      // a new event wins over a simultaneous acknowledge
      st_q <= (st_q & ~ack) | set;
      if (mask_we) begin
        mk_q <= mask_d;
      end
    end
  end

endmodule

// File: rtl/ivtimer.sv
`timescale 1ns/1ps
module ivtimer
  import ivtimer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int RATE_W   = 2,
  parameter int PRE_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);

  localparam int NSRC = 1;

  logic [CNT_W-1:0]  div_q;
  op_e               op_q;
  logic [RATE_W-1:0] rate_q;

  logic              ctrl_wr;
  logic              load_pulse;
  logic              running;
  logic              tick;
  logic              uf;
  logic [CNT_W-1:0]  count_q;
  logic [NSRC-1:0]   status_q;
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   masked;
  logic [NSRC-1:0]   ack_vec;

  assign ctrl_wr    = wr_en && (wr_addr == A_CTRL);
  assign load_pulse = ctrl_wr && (wr_data[OP_LSB +: 2] == OP_LOAD);
  assign running    = (op_q == OP_RUN);
  assign ack_vec    = (wr_en && (wr_addr == A_ACK)) ? wr_data[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      op_q   <= OP_HOLD;
      rate_q <= '0;
    end else begin
      if (wr_en && (wr_addr == A_DIV)) begin
        div_q <= wr_data;
      end
      if (ctrl_wr) begin
        op_q   <= op_e'(wr_data[OP_LSB +: 2]);
        rate_q <= wr_data[RATE_LSB +: RATE_W];
      end
    end
  end

  ivt_prescaler #(
    .SEL_W    (RATE_W),
    .PRE_STEP (PRE_STEP)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .restart (ctrl_wr),
    .sel     (rate_q),
    .tick    (tick)
  );

  ivt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_pulse),
    .tick       (tick),
    .reload_val (div_q),
    .count      (count_q),
    .wrap       (uf)
  );

  ivt_irq #(
    .NSRC (NSRC)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (uf),
    .ack     (ack_vec),
    .mask_we (wr_en && (wr_addr == A_MASK)),
    .mask_d  (wr_data[NSRC-1:0]),
    .status  (status_q),
    .mask    (mask_q),
    .masked  (masked),
    .irq     (irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_DIV:   rd_data = div_q;
      A_CTRL:  rd_data = CNT_W'({rate_q, op_q});
      A_COUNT: rd_data = count_q;
      A_MASK:  rd_data = CNT_W'(mask_q);
      A_MSTAT: rd_data = CNT_W'(masked);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/ivtimer_chk.sv
`timescale 1ns/1ps
module ivtimer_chk
  import ivtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] div,
  input logic             running,
  input logic             tick,
  input logic             uf,
  input logic             st
);

  logic ld;
  logic ack;
  assign ld  = wr_en && (wr_addr == A_CTRL) && (wr_data[1:0] == 2'd1);
  assign ack = wr_en && (wr_addr == A_ACK) && wr_data[0];

  a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> count == $past(div));

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && count > 1) |=> count == $past(count) - 1'b1);

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ld) |=> $stable(count));

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> count == $past(div));

  a_r7_sets: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> st);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !uf) |=> !st);

  a_r10_race_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && uf) |=> st);

endmodule

bind ivtimer ivtimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .count   (count_q),
  .div     (div_q),
  .running (running),
  .tick    (tick),
  .uf      (uf),
  .st      (status_q[0])
);

// File: tb/ivtimer_tb_top.sv
`timescale 1ns/1ps
module ivtimer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ivtimer dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (irq)
  );

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  // stop, clear pending, then load and start with divisor d and rate code r
  task automatic start(input logic [31:0] d, input int r);
    wr(3'd1, 32'd0);
    wr(3'd5, 32'd1);
    wr(3'd0, d);
    wr(3'd1, 32'd1);
    wr(3'd1, 32'(r << 2) | 32'd2);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd2, v); chk("R1 count", v, 0);
    rd(3'd0, v); chk("R1 divisor", v, 0);
    rd(3'd3, v); chk("R1 mask", v, 0);
    rd(3'd4, v); chk("R1 masked status", v, 0);
    chk("R1 irq", irq, 0);
    rd(3'd7, v); chk("R11 unmapped read", v, 0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd10);
    wr(3'd1, 32'd1);
    rd(3'd2, v); chk("R2 load copies divisor", v, 10);
    step(5);
    rd(3'd2, v); chk("R2 loaded counter stays", v, 10);
    wr(3'd2, 32'd99);
    rd(3'd2, v); chk("R11 write to counter ignored", v, 10);
    rd(3'd1, v); chk("R11 control readback", v, 1);
  endtask

  task automatic t_run_wrap();
    logic [31:0] v;
    wr(3'd3, 32'd0);
    start(32'd10, 0);
    rd(3'd2, v); chk("R3 start value", v, 10);
    step(3);
    rd(3'd2, v); chk("R3 decrement per tick", v, 7);
    step(6);
    rd(3'd2, v); chk("R5 value before wrap", v, 1);
    step(1);
    rd(3'd2, v); chk("R5 reload after wrap", v, 10);
    rd(3'd4, v); chk("R8 masked read with mask 0", v, 0);
    chk("R8 irq low with mask 0", irq, 0);
    wr(3'd3, 32'd1);
    rd(3'd4, v); chk("R7 status set by wrap", v, 1);
    chk("R8 irq high", irq, 1);
    step(3);
    chk("R8 irq held until acknowledge", irq, 1);
    wr(3'd5, 32'd0);
    rd(3'd4, v); chk("R9 ack with bit clear ignored", v, 1);
    wr(3'd4, 32'd0);
    rd(3'd4, v); chk("R11 write to status address ignored", v, 1);
    wr(3'd5, 32'd1);
    rd(3'd4, v); chk("R9 ack clears", v, 0);
    chk("R9 irq low after ack", irq, 0);
  endtask

  task automatic t_hold();
    logic [31:0] v, w;
    start(32'd50, 0);
    step(4);
    wr(3'd1, 32'd3);
    rd(3'd2, v);
    step(6);
    rd(3'd2, w); chk("R3 hold freezes counter", w, v);
  endtask

  task automatic t_rate();
    logic [31:0] v;
    start(32'd3, 1);
    step(3);
    rd(3'd2, v); chk("R4 no tick before 4 clocks", v, 3);
    step(1);
    rd(3'd2, v); chk("R4 tick at 4 clocks", v, 2);
    step(4);
    rd(3'd2, v); chk("R4 second tick", v, 1);
    step(4);
    rd(3'd2, v); chk("R5 wrap at slow rate", v, 3);
    rd(3'd4, v); chk("R7 status at slow rate", v, 1);
  endtask

  task automatic t_div_change();
    logic [31:0] v;
    start(32'd5, 0);
    wr(3'd0, 32'd8);
    rd(3'd2, v); chk("R6 counter unchanged by divisor write", v, 4);
    rd(3'd0, v); chk("R11 divisor readback", v, 8);
    step(3);
    rd(3'd2, v); chk("R6 old sequence continues", v, 1);
    step(1);
    rd(3'd2, v); chk("R6 new divisor at reload", v, 8);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(3'd3, 32'd1);
    start(32'd3, 0);
    step(2);
    wr(3'd5, 32'd1);
    rd(3'd2, v); chk("R10 reloaded on race edge", v, 3);
    rd(3'd4, v); chk("R10 status kept on race", v, 1);
    chk("R10 irq kept on race", irq, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_run_wrap();
    t_hold();
    t_rate();
    t_div_change();
    t_race();
    step(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule